// File: doc/BRIEF.md
# Compressed Weight Expander to Half Precision

This block sits in front of the multiplier array. Packed weight bytes arrive one per handshake. The block rebuilds them into dense IEEE half-precision (fp16) weights, so the arithmetic after it only ever sees fp16 values. It emits one vector of `LANES` weights per output handshake.

It decodes three formats:
- **4-bit table indices.** Each index selects one of 16 fp16 values held in a table that software loads.
- **Signed 8-bit values with a per-block scale.** Each value is multiplied by an fp16 scale that leads its block.
- **Two-of-four sparse groups.** A presence mask is followed by only the two stored values of each group.

Weights are grouped in blocks of `BLOCK_W` dense weights. The active format and the table can change only between blocks. Output order always matches dense weight order: lane 0 sits in bits [15:0] and carries the earliest weight of the beat.

Top module: `wdec_fp16_expand`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready`, `mode_ready` and `lut_ready` are 1. The active format is table mode (code 0).
- R2: In table mode (code 0), each byte yields two weights: first the table entry chosen by bits [3:0], then the entry chosen by bits [7:4]. The two weights fill consecutive lanes.
- R3: A table write (`lut_valid && lut_ready`) stores `lut_data` at `lut_addr`. Every later table-mode byte reads the new value.
- R4: In scaled mode (code 1), each block begins with a scale in two bytes, low byte first. The scale is followed by `BLOCK_W` two's-complement bytes. Each output is the byte value times the scale, rounded to nearest-even fp16.
- R5: In scaled mode, the product is +0 (16'h0000) when the byte is 0 or the scale exponent field is 0. The product is signed infinity when the scale exponent field is 31 or the rounded result exceeds the fp16 range.
- R6: In sparse mode (code 2), each group of four weights takes five bytes:
  - a mask byte, of which only bits [3:0] are used, with exactly two bits set;
  - then two fp16 values, each sent low byte first.
  The first value lands in the lane of the lowest set mask bit and the second in the lane of the highest. The other two lanes are 16'h0000.
- R7: `mode_ready` and `lut_ready` are low inside a block. A mode write with code 3 leaves the active format unchanged.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds steady and `in_ready` stays low.
- R9: Vectors come out in dense weight order, `BLOCK_W/LANES` per block, with every lane written from the input. Each vector appears only after an accepted input byte.
- R10: A scale applies to its own block only. The next block's scale replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_valid | input | 1 | Format write request |
| mode_sel | input | 2 | Format code: 0 table, 1 scaled, 2 sparse, 3 ignored |
| mode_ready | output | 1 | High between blocks |
| lut_valid | input | 1 | Table write request |
| lut_addr | input | 4 | Table entry index |
| lut_data | input | 16 | fp16 table value |
| lut_ready | output | 1 | High between blocks |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Compressed stream byte |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |
| out_valid | output | 1 | Output vector valid |
| out_data | output | LANES*16 | Dense fp16 weights, lane 0 in bits [15:0] |
| out_ready | input | 1 | Output vector taken |

## Verification
The table path is swept over all 256 byte values, and then re-run after the table is rewritten. A decoder that swapped nibbles, or that kept the old entries, would put the wrong value in alternate lanes.

The scaled path is swept over all 256 signed bytes under eight scales. These include non-integral, maximal, subnormal and infinite scales. Wrong rounding would move the last mantissa bit. A missed overflow, or a sticky scale, would show up as finite values where infinity is expected, or as one block's scale leaking into the next.

Sparse groups cover all six legal masks. Junk is placed in the mask's upper bits, which catches misplaced or unzeroed lanes.

Beyond that, the bench checks three more things:
- format and table writes are refused mid-block, and code 3 is ignored;
- output data stays frozen under backpressure;
- a lost or duplicated beat would break the in-order comparison.

// File: rtl/wdec_pkg.sv
package wdec_pkg;

    typedef enum logic [1:0] {
        FMT_LUT4   = 2'd0,
        FMT_INT8   = 2'd1,
        FMT_SPARSE = 2'd2
    } fmt_e;

    localparam int LUT_DEPTH = 16;
    localparam int LUT_AW    = $clog2(LUT_DEPTH);
    localparam int FP_W      = 16;
    localparam int GROUP     = 4;

    function automatic logic [1:0] first_set(input logic [3:0] m);
        logic [1:0] p;
        p = 2'd0;
        for (int i = 3; i >= 0; i--)
            if (m[i]) p = 2'(i);
        return p;
    endfunction

    function automatic logic [1:0] last_set(input logic [3:0] m);
        logic [1:0] p;
        p = 2'd0;
        for (int i = 0; i < 4; i++)
            if (m[i]) p = 2'(i);
        return p;
    endfunction

endpackage

// File: rtl/wdec_lut.sv
module wdec_lut
    import wdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [LUT_AW-1:0] waddr,
    input  logic [FP_W-1:0]   wdata,
    input  logic [LUT_AW-1:0] raddr_a,
    input  logic [LUT_AW-1:0] raddr_b,
    output logic [FP_W-1:0]   rdata_a,
    output logic [FP_W-1:0]   rdata_b
);
    logic [FP_W-1:0] tbl [LUT_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LUT_DEPTH; i++) tbl[i] <= '0;
        end else if (we) begin
            tbl[waddr] <= wdata;
        end
    end

    assign rdata_a = tbl[raddr_a];
    assign rdata_b = tbl[raddr_b];
endmodule

// File: rtl/wdec_qmul.sv
module wdec_qmul
    import wdec_pkg::*;
(
    input  logic [7:0]      q,
    input  logic [FP_W-1:0] scale,
    output logic [FP_W-1:0] y
);
    logic        sgn;
    logic [4:0]  es;
    logic [7:0]  mag;
    logic [18:0] prod;
    logic [4:0]  lead;
    logic [2:0]  sh;
    logic [10:0] kept;
    logic [18:0] rem;
    logic [18:0] half;
    logic        up;
    logic [11:0] k2;
    logic [6:0]  ef;

    always_comb begin
        sgn  = q[7] ^ scale[15];
        es   = scale[14:10];
        mag  = q[7] ? (~q + 8'd1) : q;
        prod = 19'(mag) * 19'({1'b1, scale[9:0]});
        lead = 5'd0;
        for (int i = 0; i < 19; i++)
            if (prod[i]) lead = 5'(i);
        sh   = 3'(lead - 5'd10);
        kept = 11'(prod >> sh);
        rem  = prod & ((19'd1 << sh) - 19'd1);
        half = (sh == 3'd0) ? 19'd0 : (19'd1 << (sh - 3'd1));
        up   = (sh != 3'd0) && ((rem > half) || ((rem == half) && kept[0]));
        k2   = {1'b0, kept} + {11'd0, up};
        ef   = 7'(lead) + 7'(es) - 7'd10 + 7'(k2[11]);
        if (mag == 8'd0 || es == 5'd0)
            y = '0;
        else if (es == 5'd31 || ef >= 7'd31)
            y = {sgn, 5'h1F, 10'h0};
        else
            y = {sgn, ef[4:0], k2[11] ? 10'h0 : k2[9:0]};
    end
endmodule

// File: rtl/wdec_assemble.sv
module wdec_assemble
    import wdec_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic [LW-1:0]         clr_base,
    input  logic                  wa_en,
    input  logic [LW-1:0]         wa_idx,
    input  logic [FP_W-1:0]       wa_val,
    input  logic                  wb_en,
    input  logic [LW-1:0]         wb_idx,
    input  logic [FP_W-1:0]       wb_val,
    input  logic                  push,
    input  logic                  out_ready,
    output logic                  full,
    output logic [LANES*FP_W-1:0] out_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_slot
        logic [FP_W-1:0] slot;
        always_ff @(posedge clk) begin
            if (rst)
                slot <= '0;
            else if (wa_en && wa_idx == LW'(g))
                slot <= wa_val;
            else if (wb_en && wb_idx == LW'(g))
                slot <= wb_val;
            else if (clr && (LW'(g) >> 2) == (clr_base >> 2))
                slot <= '0;
        end
        assign out_data[g*FP_W +: FP_W] = slot;
    end

    always_ff @(posedge clk) begin
        if (rst)
            full <= 1'b0;
        else if (push)
            full <= 1'b1;
        else if (full && out_ready)
            full <= 1'b0;
    end
endmodule

// File: rtl/wdec_fp16_expand.sv
module wdec_fp16_expand
    import wdec_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int BLOCK_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode_valid,
    input  logic [1:0]            mode_sel,
    output logic                  mode_ready,
    input  logic                  lut_valid,
    input  logic [3:0]            lut_addr,
    input  logic [15:0]           lut_data,
    output logic                  lut_ready,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic [LANES*16-1:0]   out_data,
    input  logic                  out_ready
);
    localparam int LW = $clog2(LANES);
    localparam int CW = $clog2(BLOCK_W);

    fmt_e            mode_q;
    logic [CW-1:0]   wcnt;
    logic [2:0]      phase;
    logic [7:0]      hold;
    logic [15:0]     scale_q;
    logic [3:0]      mask_q;
    logic            full;
    logic            boundary;
    logic            acc;
    logic [LW-1:0]   base;
    logic [15:0]     lut_lo, lut_hi, qy;

    logic            clr, wa_en, wb_en, push;
    logic [LW-1:0]   wa_idx, wb_idx;
    logic [15:0]     wa_val, wb_val;
    logic [2:0]      step;
    logic [2:0]      nxt_phase;
    logic [CW:0]     sum;
    logic [CW-1:0]   wcnt_nxt;

    assign boundary   = (wcnt == '0) && (phase == 3'd0);
    assign mode_ready = boundary;
    assign lut_ready  = boundary;
    assign in_ready   = !full && !(boundary && (mode_valid || lut_valid));
    assign acc        = in_valid && in_ready;
    assign base       = wcnt[LW-1:0];
    assign out_valid  = full;

    wdec_lut u_lut (
        .clk(clk), .rst(rst),
        .we(lut_valid && lut_ready), .waddr(lut_addr), .wdata(lut_data),
        .raddr_a(in_byte[3:0]), .raddr_b(in_byte[7:4]),
        .rdata_a(lut_lo), .rdata_b(lut_hi)
    );

    wdec_qmul u_qmul (.q(in_byte), .scale(scale_q), .y(qy));

    always_comb begin
        clr = 1'b0; wa_en = 1'b0; wb_en = 1'b0;
        wa_idx = base; wb_idx = base;
        wa_val = '0; wb_val = '0;
        step = 3'd0; nxt_phase = phase;
        if (acc) begin
            unique case (mode_q)
                FMT_LUT4: begin
                    wa_en = 1'b1; wa_val = lut_lo;
                    wb_en = 1'b1; wb_idx = base + LW'(1); wb_val = lut_hi;
                    step = 3'd2;
                end
                FMT_INT8: begin
                    if (phase == 3'd0) nxt_phase = 3'd1;
                    else if (phase == 3'd1) nxt_phase = 3'd2;
                    else begin
                        wa_en = 1'b1; wa_val = qy; step = 3'd1;
                        if (wcnt == CW'(BLOCK_W - 1)) nxt_phase = 3'd0;
                    end
                end
                FMT_SPARSE: begin
                    unique case (phase)
                        3'd0: begin clr = 1'b1; nxt_phase = 3'd1; end
                        3'd1: nxt_phase = 3'd2;
                        3'd2: begin
                            wa_en = 1'b1; wa_idx = base + LW'(first_set(mask_q));
                            wa_val = {in_byte, hold}; nxt_phase = 3'd3;
                        end
                        3'd3: nxt_phase = 3'd4;
                        default: begin
                            wa_en = 1'b1; wa_idx = base + LW'(last_set(mask_q));
                            wa_val = {in_byte, hold}; step = 3'd4; nxt_phase = 3'd0;
                        end
                    endcase
                end
                default: ;
            endcase
        end
        sum      = {1'b0, wcnt} + (CW+1)'(step);
        wcnt_nxt = (sum == (CW+1)'(BLOCK_W)) ? '0 : sum[CW-1:0];
        push     = (step != 3'd0) && (int'(base) + int'(step) == LANES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= FMT_LUT4;
            wcnt    <= '0;
            phase   <= 3'd0;
            hold    <= '0;
            scale_q <= '0;
            mask_q  <= '0;
        end else begin
            if (mode_valid && mode_ready && mode_sel != 2'd3)
                mode_q <= fmt_e'(mode_sel);
            if (acc) begin
                phase <= nxt_phase;
                wcnt  <= wcnt_nxt;
                hold  <= in_byte;
                if (mode_q == FMT_INT8 && phase == 3'd1)
                    scale_q <= {in_byte, hold};
                if (mode_q == FMT_SPARSE && phase == 3'd0)
                    mask_q <= in_byte[3:0];
            end
        end
    end

    wdec_assemble #(.LANES(LANES)) u_asm (
        .clk(clk), .rst(rst),
        .clr(clr), .clr_base(base),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_val(wa_val),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
        .push(push), .out_ready(out_ready),
        .full(full), .out_data(out_data)
    );
endmodule

// File: rtl/wdec_fp16_expand_chk.sv
module wdec_fp16_expand_chk #(
    parameter int LANES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                mode_valid,
    input logic                mode_ready,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [LANES*16-1:0] out_data,
    input logic [1:0]          mode_q
);
    logic sparse_ok;

    always_comb begin
        sparse_ok = 1'b1;
        for (int g = 0; g < LANES / 4; g++) begin
            int nz;
            nz = 0;
            for (int k = 0; k < 4; k++)
                if (out_data[(g*4+k)*16 +: 15] != 15'd0) nz++;
            if (nz > 2) sparse_ok = 1'b0;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_mode_edge_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> $past(mode_valid && mode_ready));

    assert_sparse_two_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) && $past(mode_q) == 2'd2 |-> sparse_ok);

    assert_beat_src_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind wdec_fp16_expand wdec_fp16_expand_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst(rst),
    .mode_valid(mode_valid), .mode_ready(mode_ready),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .mode_q(mode_q)
);

// File: tb/tb_wdec_fp16_expand.sv
module tb_wdec_fp16_expand;
    localparam int LANES   = 4;
    localparam int BLOCK_W = 32;
    localparam int VW      = LANES * 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_valid = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic          mode_ready;
    logic          lut_valid = 1'b0;
    logic [3:0]    lut_addr = 4'd0;
    logic [15:0]   lut_data = 16'd0;
    logic          lut_ready;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'd0;
    logic          in_ready;
    logic          out_valid;
    logic [VW-1:0] out_data;
    logic          out_ready = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [VW-1:0] exp_q[$];
    string         tag_q[$];
    logic [15:0]   model_lut [16];

    always #5 clk = ~clk;

    wdec_fp16_expand #(.LANES(LANES), .BLOCK_W(BLOCK_W)) dut (
        .clk(clk), .rst(rst),
        .mode_valid(mode_valid), .mode_sel(mode_sel), .mode_ready(mode_ready),
        .lut_valid(lut_valid), .lut_addr(lut_addr), .lut_data(lut_data), .lut_ready(lut_ready),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Output monitor: in-order comparison (R9) per lane.
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected beat", 64'(out_data), 64'hDEAD);
            end else begin
                logic [VW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                for (int l = 0; l < LANES; l++)
                    chk(t, 64'(out_data[l*16 +: 16]), 64'(e[l*16 +: 16]));
            end
        end
    end

    function automatic logic [15:0] ref_q(int q, logic [15:0] s);
        int  es;
        real v, m, fl;
        int  e, mi;
        logic sg;
        es = int'(s[14:10]);
        sg = (q < 0) ^ s[15];
        if (q == 0 || es == 0) return 16'h0000;
        if (es == 31) return {sg, 15'h7C00};
        v = real'(q < 0 ? -q : q) * (1024.0 + real'(s[9:0])) * (2.0 ** (es - 25));
        e = -30;
        while ((2.0 ** (e + 1)) <= v) e++;
        m  = v / (2.0 ** (e - 10));
        fl = $floor(m);
        mi = int'(fl);
        if ((m - fl) > 0.5 || ((m - fl) == 0.5 && (mi % 2) == 1)) mi++;
        if (mi == 2048) begin mi = 1024; e++; end
        if (e > 15) return {sg, 15'h7C00};
        return {sg, 5'(e + 15), 10'(mi - 1024)};
    endfunction

    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic write_mode(logic [1:0] m);
        @(negedge clk);
        mode_valid = 1'b1; mode_sel = m;
        while (!mode_ready) @(negedge clk);
        @(posedge clk); #1;
        mode_valid = 1'b0;
    endtask

    task automatic write_lut(int a, logic [15:0] d);
        @(negedge clk);
        lut_valid = 1'b1; lut_addr = 4'(a); lut_data = d;
        while (!lut_ready) @(negedge clk);
        @(posedge clk); #1;
        lut_valid = 1'b0;
        model_lut[a] = d;
    endtask

    function automatic logic [VW-1:0] lut_vec(logic [7:0] b0, logic [7:0] b1);
        return {model_lut[b1[7:4]], model_lut[b1[3:0]], model_lut[b0[7:4]], model_lut[b0[3:0]]};
    endfunction

    task automatic lut_block(int k, string tag);
        for (int j = 0; j < 16; j += 2) begin
            logic [7:0] b0, b1;
            b0 = 8'(k * 16 + j);
            b1 = 8'(k * 16 + j + 1);
            exp_q.push_back(lut_vec(b0, b1)); tag_q.push_back(tag);
            send_byte(b0);
            send_byte(b1);
        end
    endtask

    task automatic int8_block(int k, logic [15:0] s, string tag);
        send_byte(s[7:0]);
        send_byte(s[15:8]);
        for (int j = 0; j < BLOCK_W; j += LANES) begin
            logic [VW-1:0] e;
            for (int l = 0; l < LANES; l++)
                e[l*16 +: 16] = ref_q((k * 32 + j + l) % 256 - 128, s);
            exp_q.push_back(e); tag_q.push_back(tag);
            for (int l = 0; l < LANES; l++)
                send_byte(8'((k * 32 + j + l) % 256 - 128));
        end
    endtask

    task automatic sparse_group(int g);
        logic [3:0]  masks [6];
        logic [3:0]  m;
        logic [15:0] v0, v1;
        logic [VW-1:0] e;
        int lo, hi;
        masks = '{4'b0011, 4'b0101, 4'b0110, 4'b1001, 4'b1010, 4'b1100};
        m  = masks[g % 6];
        v0 = 16'(16'h3800 + g * 293);
        v1 = 16'(16'hB800 + g * 171);
        lo = -1; hi = -1;
        for (int i = 0; i < 4; i++) if (m[i]) begin if (lo < 0) lo = i; hi = i; end
        e = '0;
        e[lo*16 +: 16] = v0;
        e[hi*16 +: 16] = v1;
        exp_q.push_back(e); tag_q.push_back("R6 sparse lanes");
        send_byte({4'(g), m});
        send_byte(v0[7:0]); send_byte(v0[15:8]);
        send_byte(v1[7:0]); send_byte(v1[15:8]);
    endtask

    task automatic drain();
        int w;
        w = 0;
        while (exp_q.size() != 0 && w < 2000) begin @(negedge clk); w++; end
        chk("R9 all beats delivered", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] scales [8];
        logic [VW-1:0] held;
        scales = '{16'h3C00, 16'hBC00, 16'h3555, 16'h7800,
                   16'h0400, 16'h0200, 16'h7BFF, 16'h7C00};
        for (int i = 0; i < 16; i++) model_lut[i] = 16'h0000;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid reset", 64'(out_valid), 64'd0);
        chk("R1 in_ready reset", 64'(in_ready), 64'd1);
        chk("R1 mode_ready reset", 64'(mode_ready), 64'd1);
        chk("R1 lut_ready reset", 64'(lut_ready), 64'd1);

        // R1/R2: table mode active from reset, exhaustive byte sweep.
        for (int i = 0; i < 16; i++)
            write_lut(i, 16'((i * 16'h1357) ^ 16'h2A00));
        for (int k = 0; k < 16; k++) lut_block(k, "R2 table decode");
        drain();

        // R3: rewrite table, decode again.
        for (int i = 0; i < 16; i++)
            write_lut(i, ~16'((i * 16'h1357) ^ 16'h2A00));
        lut_block(5, "R3 table rewrite");
        lut_block(10, "R3 table rewrite");

        // R7: mid-block refusal of format/table writes.
        exp_q.push_back(lut_vec(8'h12, 8'h34)); tag_q.push_back("R7 mid-block data");
        send_byte(8'h12);
        @(negedge clk);
        chk("R7 mode_ready mid-block", 64'(mode_ready), 64'd0);
        chk("R7 lut_ready mid-block", 64'(lut_ready), 64'd0);
        send_byte(8'h34);
        for (int j = 2; j < 16; j += 2) begin
            exp_q.push_back(lut_vec(8'(j), 8'(j + 1))); tag_q.push_back("R7 mid-block data");
            send_byte(8'(j)); send_byte(8'(j + 1));
        end

        // R8: backpressure.
        @(posedge clk); #1 out_ready = 1'b0;
        exp_q.push_back(lut_vec(8'hA5, 8'h5A)); tag_q.push_back("R8 held beat");
        send_byte(8'hA5);
        send_byte(8'h5A);
        @(negedge clk);
        held = out_data;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R8 out_valid held", 64'(out_valid), 64'd1);
            chk("R8 in_ready low", 64'(in_ready), 64'd0);
            chk("R8 data stable", 64'(out_data), 64'(held));
        end
        @(posedge clk); #1 out_ready = 1'b1;
        for (int j = 2; j < 16; j += 2) begin
            exp_q.push_back(lut_vec(8'(j * 7), 8'(j * 7 + 1))); tag_q.push_back("R8 after release");
            send_byte(8'(j * 7)); send_byte(8'(j * 7 + 1));
        end
        drain();

        // R4/R5/R10: scaled mode, all signed bytes, eight scales.
        write_mode(2'd1);
        for (int k = 0; k < 8; k++) int8_block(k, scales[k], "R4 R5 R10 scaled decode");
        drain();

        // R7: code 3 ignored, scaled mode stays.
        write_mode(2'd3);
        int8_block(3, 16'h3555, "R7 code 3 ignored");
        drain();

        // R6: sparse groups, all legal masks.
        write_mode(2'd2);
        for (int g = 0; g < 16; g++) sparse_group(g);
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule